// File: doc/BRIEF.md
# I2C Word-Access Register Target

This block is the serial front end of a sensor. It sits on a two-wire I2C bus as a target with one fixed 7-bit address and holds a small bank of 16-bit words. Each word is selected by an 8-bit command code. A host writes a word by sending the address with the write bit, then the command code, then the low data byte and then the high data byte. A read is one combined transaction. The host writes the command code, issues a repeated start instead of a stop, sends the address again with the read bit, and then clocks out the low byte followed by the high byte.

The bank has seven read/write words. Code 0x00 is the configuration word, and its value leaves the block on a port. Codes 0x01 to 0x06 are spare read/write words. Codes 0x07 to 0x0B are read-only result words, supplied on an input bus by the measurement logic. Code 0x0C is a fixed identification word. Both bus lines are oversampled by the system clock through two-flop synchronisers. The block only pulls SDA low: it raises an output enable, and the pad logic outside turns that enable into an open-drain driver.

Top module: `i2c_word_target`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal 0x10. For any other address it keeps SDA released for the rest of that transaction and changes no register.
- R2: The first byte after a matching address with the write bit (bit 0 = 0) is the command code. It selects the word used by the following data bytes and by a later read.
- R3: A write commits the low byte and the high byte together as one 16-bit word, and only once the high byte has been received. A transaction that ends after the low byte leaves the word unchanged. The configuration port changes only through such a commit.
- R4: Data bytes beyond the second in a write transaction are not acknowledged (SDA stays high in their ACK slot), and they change nothing.
- R5: A read transaction consists of: write address, command code, repeated start, then the address with the read bit (bit 0 = 1). It returns the low byte first, most significant bit first. After the host ACKs the low byte, the high byte follows. After the host NACKs the high byte, the block releases SDA.
- R6: Code 0x00 resets to 0x0000 and its value appears on `cfgWord`. Codes 0x01 to 0x06 reset to 0x0000 and read back the last committed value.
- R7: Codes 0x07 to 0x0B read the result input: code 0x07+k returns `resultIn[16k+15:16k]`. Writes to these codes are acknowledged and discarded.
- R8: Code 0x0C always reads 0x0026. Codes 0x0D to 0xFF read 0x0000. Writes to either range are acknowledged and discarded.
- R9: The word to be read is captured when the read address is acknowledged. Later changes on `resultIn` do not alter either byte of that transfer.
- R10: The block changes its SDA drive only while SCL is low. It drives nothing after a stop, and nothing after reset.
- R11: A start condition seen at any point aborts the transfer in progress. A write cut short this way commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level sensed at the pad |
| sdaIn | input | 1 | SDA level sensed at the pad |
| sdaPullLow | output | 1 | High to pull SDA low (open-drain enable) |
| cfgWord | output | 16 | Current value of the configuration word (code 0x00) |
| resultIn | input | 80 | Five result words from the measurement logic, code 0x07 in bits 15:0 |

## Verification
Two events can coincide: the measurement logic updating `resultIn`, and a host transfer of that same result word. The bench provokes this by changing the result bus after the low byte has gone out and before the high byte is clocked. It then requires that both bytes come from the value present when the read address was acknowledged. A second pairing is a repeated start that arrives while a write still holds a pending low byte. The bench checks that the word stays at its old value.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;
  typedef struct packed {
    logic setCmd;
    logic setLow;
    logic commit;
    logic loadRead;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } state_t;
endpackage

// File: rtl/i2c_word_ctrl.sv
module i2c_word_ctrl
  import i2c_word_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [WORD_W-1:0] readLatch,
  output logic [WORD_W/2-1:0] rxByte,
  output strobe_t           strobe,
  output logic              sdaPullLow
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic sclQ1, sclS, sclD, sdaQ1, sdaS, sdaD;
  logic startEv, stopEv, sclRise, sclFall, byteEnd, addrHit;
  state_t state;
  logic [CNT_W-1:0]  bitCnt;
  logic [2:0]        byteNum;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic isRead, txHi, mAck, pull;

  // two-flop synchronisers plus one delayed copy for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclQ1, sclS, sclD} <= 3'b111;
      {sdaQ1, sdaS, sdaD} <= 3'b111;
    end else begin
      {sclQ1, sclS, sclD} <= {sclIn, sclQ1, sclS};
      {sdaQ1, sdaS, sdaD} <= {sdaIn, sdaQ1, sdaS};
    end
  end

  assign startEv = sclS && sclD && sdaD && !sdaS;
  assign stopEv  = sclS && sclD && !sdaD && sdaS;
  assign sclRise = sclS && !sclD;
  assign sclFall = !sclS && sclD;
  assign byteEnd = (state == ST_RX) && sclFall && (bitCnt == CNT_W'(BYTE_W));
  assign addrHit = (rxShift[BYTE_W-1:1] == TARGET_ADDR);

  always_comb begin
    strobe.setCmd   = byteEnd && (byteNum == 3'd1);
    strobe.setLow   = byteEnd && (byteNum == 3'd2);
    strobe.commit   = byteEnd && (byteNum == 3'd3);
    strobe.loadRead = byteEnd && (byteNum == 3'd0) && addrHit && rxShift[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteNum <= '0;
      rxShift <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      txHi    <= 1'b0;
      mAck    <= 1'b0;
      pull    <= 1'b0;
    end else if (startEv) begin
      state   <= ST_RX;
      bitCnt  <= '0;
      byteNum <= '0;
      pull    <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            rxShift <= {rxShift[BYTE_W-2:0], sdaS};
            bitCnt  <= bitCnt + 1'b1;
          end else if (byteEnd) begin
            bitCnt  <= '0;
            byteNum <= (byteNum == 3'd4) ? 3'd4 : byteNum + 3'd1;
            if (byteNum == 3'd0) begin
              if (addrHit) begin
                isRead <= rxShift[0];
                pull   <= 1'b1;
                state  <= ST_RXACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              pull  <= (byteNum != 3'd4);
              state <= ST_RXACK;
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            if (isRead) begin
              state   <= ST_TX;
              txShift <= readLatch[BYTE_W-1:0];
              pull    <= ~readLatch[BYTE_W-1];
              txHi    <= 1'b0;
            end else begin
              state <= ST_RX;
              pull  <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == CNT_W'(BYTE_W)) begin
              state  <= ST_TXACK;
              pull   <= 1'b0;
              bitCnt <= '0;
            end else begin
              txShift <= {txShift[BYTE_W-2:0], 1'b0};
              pull    <= ~txShift[BYTE_W-2];
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            mAck <= ~sdaS;
          end else if (sclFall) begin
            if (mAck && !txHi) begin
              state   <= ST_TX;
              txShift <= readLatch[WORD_W-1:BYTE_W];
              pull    <= ~readLatch[WORD_W-1];
              txHi    <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rxByte     = rxShift;
  assign sdaPullLow = pull;
endmodule

// File: rtl/i2c_word_regs.sv
module i2c_word_regs
  import i2c_word_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_RW = 7,
  parameter int NUM_RES = 5,
  parameter logic [15:0] ID_CODE = 16'h0026
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  strobe_t                   strobe,
  input  logic [WORD_W/2-1:0]       rxByte,
  input  logic [NUM_RES*WORD_W-1:0] resultIn,
  output logic [WORD_W-1:0]         readLatch,
  output logic [WORD_W-1:0]         cfgWord
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int ID_CMD = NUM_RW + NUM_RES;

  logic [BYTE_W-1:0] cmdPtr, lowHold;
  logic [WORD_W-1:0] rwWords [NUM_RW];
  logic [WORD_W-1:0] selWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdPtr  <= '0;
      lowHold <= '0;
    end else begin
      if (strobe.setCmd) cmdPtr  <= rxByte;
      if (strobe.setLow) lowHold <= rxByte;
    end
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rwWords[g] <= '0;
      else if (strobe.commit && (cmdPtr == BYTE_W'(g))) rwWords[g] <= {rxByte, lowHold};
    end
  end

  always_comb begin
    selWord = '0;
    for (int k = 0; k < NUM_RW; k++)
      if (cmdPtr == BYTE_W'(k)) selWord = rwWords[k];
    for (int k = 0; k < NUM_RES; k++)
      if (cmdPtr == BYTE_W'(NUM_RW + k)) selWord = resultIn[k*WORD_W +: WORD_W];
    if (cmdPtr == BYTE_W'(ID_CMD)) selWord = WORD_W'(ID_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readLatch <= '0;
    else if (strobe.loadRead) readLatch <= selWord;
  end

  assign cfgWord = rwWords[0];
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2c_word_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h10,
  parameter int WORD_W = 16,
  parameter int NUM_RW = 7,
  parameter int NUM_RES = 5,
  parameter logic [15:0] ID_CODE = 16'h0026
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  output logic                      sdaPullLow,
  output logic [WORD_W-1:0]         cfgWord,
  input  logic [NUM_RES*WORD_W-1:0] resultIn
);
  strobe_t strobe;
  logic [WORD_W/2-1:0] rxByte;
  logic [WORD_W-1:0]   readLatch;

  i2c_word_ctrl #(.TARGET_ADDR(TARGET_ADDR), .WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .readLatch(readLatch), .rxByte(rxByte), .strobe(strobe),
    .sdaPullLow(sdaPullLow)
  );

  i2c_word_regs #(.WORD_W(WORD_W), .NUM_RW(NUM_RW), .NUM_RES(NUM_RES),
                  .ID_CODE(ID_CODE)) i_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxByte(rxByte),
    .resultIn(resultIn), .readLatch(readLatch), .cfgWord(cfgWord)
  );
endmodule

// File: rtl/i2c_word_checker.sv
module i2c_word_checker
  import i2c_word_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sdaPullLow,
  input logic [WORD_W-1:0] cfgWord,
  input strobe_t           strobe
);
  logic c1, c2, c3, d1, d2, d3, busIdle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c1, c2, c3} <= 3'b111;
      {d1, d2, d3} <= 3'b111;
      busIdle <= 1'b1;
    end else begin
      {c1, c2, c3} <= {sclIn, c1, c2};
      {d1, d2, d3} <= {sdaIn, d1, d2};
      if (c2 && c3 && d3 && !d2) busIdle <= 1'b0;
      else if (c2 && c3 && !d3 && d2) busIdle <= 1'b1;
    end
  end

  // R10: drive level held while SCL (as synchronised) stays high
  assert_sda_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (c2 && c3) |=> $stable(sdaPullLow));

  // R10: nothing driven between a stop and the next start
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busIdle |-> !sdaPullLow);

  // R3: configuration word moves only right after a word commit
  assert_cfg_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfgWord) |-> $past(strobe.commit));

  // R9: capture of the read word never coincides with a write action
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
endmodule

bind i2c_word_target i2c_word_checker #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaPullLow(sdaPullLow), .cfgWord(cfgWord), .strobe(strobe)
);

// File: tb/test_i2c_word_target.sv
module test_i2c_word_target;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPullLow;
  logic [15:0] cfgWord;
  logic [79:0] resultIn = '0;
  wire sdaBus = sdaM & ~sdaPullLow;

  int testsRun = 0, testsFailed = 0;
  bit finished = 1'b0;
  logic [15:0] rwModel [7];
  int unsigned seedDummy;

  always #10 clk = ~clk;

  i2c_word_target i_i2c_word_target (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .cfgWord(cfgWord), .resultIn(resultIn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    waitq(); sdaM = 1'b1; waitq(); sclM = 1'b1; waitq(); sdaM = 1'b0; waitq(); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitq(); sdaM = 1'b0; waitq(); sclM = 1'b1; waitq(); sdaM = 1'b1; waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      waitq(); sdaM = b[i]; waitq(); sclM = 1'b1; waitq(); waitq(); sclM = 1'b0;
    end
    waitq(); sdaM = 1'b1; waitq(); sclM = 1'b1; waitq();
    ack = !sdaBus;
    waitq(); sclM = 1'b0;
  endtask

  task automatic recvByte(input bit hostAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(); waitq(); sclM = 1'b1; waitq();
      b[i] = sdaBus;
      waitq(); sclM = 1'b0;
    end
    waitq(); sdaM = !hostAck; waitq(); sclM = 1'b1; waitq(); waitq(); sclM = 1'b0;
    waitq(); sdaM = 1'b1;
  endtask

  task automatic writeWord(input logic [6:0] a, input logic [7:0] cmd, input logic [15:0] d, output bit ok);
    bit a0, a1, a2, a3;
    busStart();
    sendByte({a, 1'b0}, a0);
    if (a0) begin
      sendByte(cmd, a1); sendByte(d[7:0], a2); sendByte(d[15:8], a3);
      ok = a1 && a2 && a3;
    end else ok = 1'b0;
    busStop();
  endtask

  task automatic readWord(input logic [7:0] cmd, input bit swapMid, input logic [79:0] newRes,
                          output logic [15:0] d, output bit ok);
    bit a0, a1, a2;
    logic [7:0] lo, hi;
    busStart();
    sendByte({ADDR, 1'b0}, a0);
    sendByte(cmd, a1);
    busStart();
    sendByte({ADDR, 1'b1}, a2);
    recvByte(1'b1, lo);
    if (swapMid) resultIn = newRes;
    recvByte(1'b0, hi);
    busStop();
    d = {hi, lo};
    ok = a0 && a1 && a2;
  endtask

  function automatic logic [15:0] expWord(input logic [7:0] cmd);
    if (cmd < 8'd7) return rwModel[cmd[2:0]];
    if (cmd < 8'd12) return resultIn[(cmd - 8'd7) * 16 +: 16];
    if (cmd == 8'd12) return 16'h0026;
    return 16'h0000;
  endfunction

  task automatic modelWrite(input logic [7:0] cmd, input logic [15:0] d);
    if (cmd < 8'd7) rwModel[cmd[2:0]] = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    bit ok, a0, a1, a2, a3, a4;
    logic [15:0] d, oldWord;
    logic [79:0] newRes;
    seedDummy = $urandom(32'h5EED);
    for (int k = 0; k < 7; k++) rwModel[k] = '0;
    for (int k = 0; k < 5; k++) resultIn[k*16 +: 16] = 16'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6 R10: reset state
    check(cfgWord == 16'h0, "R6 reset cfgWord", 32'(cfgWord), 32'h0);
    check(sdaPullLow == 1'b0, "R10 reset release", 32'(sdaPullLow), 32'h0);

    // R8 R5: identification word via combined read
    readWord(8'h0C, 1'b0, '0, d, ok);
    check(ok, "R5 read acks", 32'(ok), 32'h1);
    check(d == 16'h0026, "R8 id word", 32'(d), 32'h0026);

    // R3 R6 R2: configuration write and readback
    writeWord(ADDR, 8'h00, 16'h1234, ok); modelWrite(8'h00, 16'h1234);
    check(ok, "R2 write acks", 32'(ok), 32'h1);
    check(cfgWord == 16'h1234, "R6 cfgWord port", 32'(cfgWord), 32'h1234);
    readWord(8'h00, 1'b0, '0, d, ok);
    check(d == 16'h1234, "R2 cfg readback", 32'(d), 32'h1234);

    // R1: foreign address
    writeWord(7'h11, 8'h00, 16'hBEEF, ok);
    check(!ok, "R1 foreign address nack", 32'(ok), 32'h0);
    check(cfgWord == 16'h1234, "R1 foreign address no effect", 32'(cfgWord), 32'h1234);

    // R7: write to a result word discarded
    writeWord(ADDR, 8'h09, 16'hA5A5, ok);
    check(ok, "R7 result write acked", 32'(ok), 32'h1);
    readWord(8'h09, 1'b0, '0, d, ok);
    check(d == expWord(8'h09), "R7 result word", 32'(d), 32'(expWord(8'h09)));

    // R8: undefined code
    writeWord(ADDR, 8'h20, 16'h5A5A, ok);
    check(ok, "R8 undefined write acked", 32'(ok), 32'h1);
    readWord(8'h20, 1'b0, '0, d, ok);
    check(d == 16'h0, "R8 undefined reads zero", 32'(d), 32'h0);

    // R3: stop after low byte only
    writeWord(ADDR, 8'h03, 16'h7788, ok); modelWrite(8'h03, 16'h7788);
    busStart(); sendByte({ADDR, 1'b0}, a0); sendByte(8'h03, a1); sendByte(8'h11, a2); busStop();
    readWord(8'h03, 1'b0, '0, d, ok);
    check(d == 16'h7788, "R3 partial write ignored", 32'(d), 32'h7788);

    // R4: extra byte nacked
    busStart(); sendByte({ADDR, 1'b0}, a0); sendByte(8'h01, a1);
    sendByte(8'hCD, a2); sendByte(8'hAB, a3); sendByte(8'hEE, a4); busStop();
    modelWrite(8'h01, 16'hABCD);
    check(a2 && a3, "R4 two data bytes acked", 32'({a2, a3}), 32'h3);
    check(!a4, "R4 extra byte nack", 32'(a4), 32'h0);
    readWord(8'h01, 1'b0, '0, d, ok);
    check(d == 16'hABCD, "R4 word intact", 32'(d), 32'hABCD);

    // R11: repeated start aborts pending write
    writeWord(ADDR, 8'h04, 16'h4444, ok); modelWrite(8'h04, 16'h4444);
    busStart(); sendByte({ADDR, 1'b0}, a0); sendByte(8'h04, a1); sendByte(8'h99, a2);
    readWord(8'h04, 1'b0, '0, d, ok);
    check(d == 16'h4444, "R11 aborted write", 32'(d), 32'h4444);

    // R9: result update during a transfer
    oldWord = expWord(8'h07);
    newRes = resultIn ^ {5{16'hFFFF}};
    readWord(8'h07, 1'b1, newRes, d, ok);
    check(d == oldWord, "R9 untorn read", 32'(d), 32'(oldWord));
    readWord(8'h07, 1'b0, '0, d, ok);
    check(d == expWord(8'h07), "R9 new value later", 32'(d), 32'(expWord(8'h07)));

    // R2 R6 R7 R8: random traffic
    for (int it = 0; it < 22; it++) begin
      logic [7:0] cmd;
      logic [15:0] val;
      cmd = 8'($urandom % 16);
      val = 16'($urandom);
      if (it % 5 == 0) resultIn[($urandom % 5) * 16 +: 16] = 16'($urandom);
      writeWord(ADDR, cmd, val, ok); modelWrite(cmd, val);
      readWord(cmd, 1'b0, '0, d, ok);
      check(d == expWord(cmd), $sformatf("R2 random cmd %h", cmd), 32'(d), 32'(expWord(cmd)));
      check(cfgWord == rwModel[0], "R6 random cfgWord", 32'(cfgWord), 32'(rwModel[0]));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule